// File: doc/BRIEF.md
# Color-Sequential Pixel Stream Stage

This stage sits in a pixel pipeline where each pixel travels as three separate 8-bit color samples on one narrow port. Blue comes first, then green, then red. The stage accepts samples on an input valid/ready port and passes them on through a small first-in first-out buffer to an output valid/ready port. On the way out it applies a saturating offset that depends on the color component. It also reports which component each outgoing sample carries.

Both ports follow a ready latency of one. A transfer happens in a cycle where valid is high and the receiver's ready was high in the previous cycle. The sink may drop its ready at any cycle without warning. The stage lowers its input ready early enough that a sample still in flight always has room in the buffer. It presents output only in a cycle after the sink showed ready.

Top module: `colseq_stage`

## Requirements
- R1: While reset is high and in the first cycle after it, in_ready is 1, out_valid is 0, and out_data and out_comp are 0.
- R2: A sample is taken in exactly those cycles where in_valid is 1 and in_ready was 1 in the previous cycle. A sample presented in any other cycle is ignored and never appears at the output.
- R3: in_ready is 1 exactly when the number of held samples plus one (counted only if in_ready was 1 in the previous cycle) is at most DEPTH-2. The buffer never overflows. A sample arriving in the cycle after in_ready falls is kept.
- R4: out_valid is 1 only in a cycle whose previous cycle had out_ready at 1.
- R5: out_valid is 1 in every cycle where out_ready was 1 in the previous cycle and at least one sample is held. Each cycle with out_valid at 1 is a transfer that removes the oldest held sample.
- R6: A component counter starts at blue after reset and moves blue, green, red, blue on each taken sample. out_comp carries the code of the outgoing sample: 0 for blue, 1 for green, 2 for red.
- R7: Samples leave in arrival order. out_data is the stored byte plus the offset of its component (blue 0x10, green 0x20, red 0x30 by default), clamped at 0xFF.
- R8: While out_valid is 0, out_data and out_comp are driven to 0.
- R9: During a sustained sink stall with the source always valid, in_ready falls and both ports stop transferring. Every sample taken before the stall is still delivered once the sink returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream sample present |
| in_data | input | 8 | Upstream color sample |
| in_ready | output | 1 | Stage can take a sample in the next cycle |
| out_ready | input | 1 | Sink can take a sample in the next cycle |
| out_valid | output | 1 | Outgoing sample present (this cycle is a transfer) |
| out_data | output | 8 | Processed color sample |
| out_comp | output | 2 | Component code of the outgoing sample |

## Verification
A sample taken at the end of cycle t is held in the buffer from cycle t+1. It can appear on the output in cycle t+1 at the earliest, and only if out_ready was high in cycle t. in_ready in cycle t depends on the buffer fill at t and on in_ready at t-1. The bench samples every output at the falling edge, away from the clock edge. It drives the inputs for that cycle right after sampling, then moves a model of the buffer forward by exactly one clock edge. That keeps each expected value aligned to the cycle the registers make it visible.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int SAMPLE_W = 8;
    localparam int COMP_W   = 2;

    typedef enum logic [COMP_W-1:0] {
        COMP_BLUE  = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_RED   = 2'd2
    } comp_e;

    typedef struct packed {
        comp_e               comp;
        logic [SAMPLE_W-1:0] val;
    } csample_t;

    function automatic comp_e comp_next(comp_e c);
        case (c)
            COMP_BLUE:  return COMP_GREEN;
            COMP_GREEN: return COMP_RED;
            default:    return COMP_BLUE;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] sat_add(logic [SAMPLE_W-1:0] a,
                                                     logic [SAMPLE_W-1:0] b);
        logic [SAMPLE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SAMPLE_W] ? {SAMPLE_W{1'b1}} : s[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/colseq_comp_tracker.sv
module colseq_comp_tracker
    import colseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output comp_e cur
);

    always_ff @(posedge clk) begin
        if (rst)       cur <= COMP_BLUE;
        else if (step) cur <= comp_next(cur);
    end

    AST_COMP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cur == COMP_RED && step) |=> cur == COMP_BLUE); // R6

    AST_COMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cur)); // R6

    AST_COMP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cur != comp_e'(2'd3)); // R6

endmodule

// File: rtl/colseq_fifo.sv
module colseq_fifo
    import colseq_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  csample_t         push_data,
    input  logic             pop,
    output csample_t         head,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    csample_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(push && !pop && count == CNT_W'(DEPTH))); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(pop && count == '0)); // R5

endmodule

// File: rtl/colseq_egress.sv
module colseq_egress
    import colseq_pkg::*;
#(
    parameter logic [SAMPLE_W-1:0] OFS_BLUE  = 8'h10,
    parameter logic [SAMPLE_W-1:0] OFS_GREEN = 8'h20,
    parameter logic [SAMPLE_W-1:0] OFS_RED   = 8'h30
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sink_ready,
    input  logic                has_data,
    input  csample_t            head,
    output logic                pop,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [COMP_W-1:0]   out_comp
);

    logic                sink_rdy_d;
    logic [SAMPLE_W-1:0] ofs;

    always_ff @(posedge clk) begin
        if (rst) sink_rdy_d <= 1'b0;
        else     sink_rdy_d <= sink_ready;
    end

    always_comb begin
        case (head.comp)
            COMP_BLUE:  ofs = OFS_BLUE;
            COMP_GREEN: ofs = OFS_GREEN;
            default:    ofs = OFS_RED;
        endcase
    end

    assign out_valid = sink_rdy_d && has_data;
    assign pop       = out_valid;
    assign out_data  = out_valid ? sat_add(head.val, ofs) : '0;
    assign out_comp  = out_valid ? head.comp : '0;

    AST_VALID_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(sink_ready)); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0 && out_comp == '0)); // R8

endmodule

// File: rtl/colseq_stage.sv
module colseq_stage
    import colseq_pkg::*;
#(
    parameter int                  DEPTH     = 4,
    parameter logic [SAMPLE_W-1:0] OFS_BLUE  = 8'h10,
    parameter logic [SAMPLE_W-1:0] OFS_GREEN = 8'h20,
    parameter logic [SAMPLE_W-1:0] OFS_RED   = 8'h30
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                in_ready,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [COMP_W-1:0]   out_comp
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W:0] FILL_LIMIT = (CNT_W + 1)'(DEPTH - 2);

    logic             in_rdy_d;
    logic             take;
    logic             pop;
    comp_e            comp_cur;
    csample_t         wr_sample;
    csample_t         head;
    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   committed;

    always_ff @(posedge clk) begin
        if (rst) in_rdy_d <= 1'b0;
        else     in_rdy_d <= in_ready;
    end

    assign committed = {1'b0, count} + {{CNT_W{1'b0}}, in_rdy_d};
    assign in_ready  = (committed <= FILL_LIMIT);
    assign take      = in_valid && in_rdy_d;

    assign wr_sample.comp = comp_cur;
    assign wr_sample.val  = in_data;

    colseq_comp_tracker u_track (
        .clk  (clk),
        .rst  (rst),
        .step (take),
        .cur  (comp_cur)
    );

    colseq_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (take),
        .push_data (wr_sample),
        .pop       (pop),
        .head      (head),
        .count     (count)
    );

    colseq_egress #(
        .OFS_BLUE  (OFS_BLUE),
        .OFS_GREEN (OFS_GREEN),
        .OFS_RED   (OFS_RED)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .sink_ready (out_ready),
        .has_data   (count != '0),
        .head       (head),
        .pop        (pop),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_comp   (out_comp)
    );

    AST_READY_BACKOFF: assert property (@(posedge clk) disable iff (rst)
        (count >= CNT_W'(DEPTH - 1)) |-> !in_ready); // R3

    AST_STALL_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !$past(out_ready) |-> !out_valid); // R9

endmodule

// File: tb/tb_colseq_stage.sv
module tb_colseq_stage;

    localparam int DEPTH = 4;
    localparam logic [7:0] OB = 8'h10, OG = 8'h20, OR = 8'h30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic [1:0] out_comp;

    always #2 clk = ~clk;

    colseq_stage dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_comp(out_comp)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] q_val[$];
    logic [1:0] q_cmp[$];
    logic [1:0] m_comp;
    bit prv_inr;
    bit prv_outr;
    int n_taken;
    int n_sent;

    function automatic logic [7:0] exp_data(logic [7:0] v, logic [1:0] c);
        logic [8:0] s;
        s = {1'b0, v} + {1'b0, (c == 2'd0) ? OB : (c == 2'd1) ? OG : OR};
        return s[8] ? 8'hFF : s[7:0];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check outputs, drive this cycle's inputs, advance model by one edge.
    task automatic step(bit v, logic [7:0] d, bit r);
        bit exp_inr, exp_ov, acc;
        @(negedge clk);
        exp_inr = (q_val.size() + int'(prv_inr)) <= DEPTH - 2;
        exp_ov  = prv_outr && (q_val.size() > 0);
        chk(in_ready == exp_inr, "R3 in_ready", in_ready, exp_inr);
        chk(out_valid == exp_ov, "R5 out_valid", out_valid, exp_ov);
        if (out_valid) chk(prv_outr, "R4 valid after ready", out_valid, prv_outr);
        if (exp_ov && out_valid) begin
            chk(out_data == exp_data(q_val[0], q_cmp[0]), "R7 data",
                out_data, exp_data(q_val[0], q_cmp[0]));
            chk(out_comp == q_cmp[0], "R6 comp", out_comp, q_cmp[0]);
        end else if (!out_valid) begin
            chk(out_data == 8'h00 && out_comp == 2'd0, "R8 idle zero",
                {out_comp, out_data}, 0);
        end
        in_valid  = v;
        in_data   = d;
        out_ready = r;
        acc = v && prv_inr; // R2: only a cycle after in_ready high takes a sample
        if (exp_ov) begin
            void'(q_val.pop_front());
            void'(q_cmp.pop_front());
            n_sent++;
        end
        if (acc) begin
            q_val.push_back(d);
            q_cmp.push_back(m_comp);
            m_comp = (m_comp == 2'd2) ? 2'd0 : m_comp + 2'd1;
            n_taken++;
        end
        prv_inr  = exp_inr;
        prv_outr = r;
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(out_data == 8'h00 && out_comp == 2'd0, "R1 reset data", out_data, 0);
        rst = 1'b0;
        q_val = {}; q_cmp = {};
        m_comp = 2'd0; prv_inr = 1'b1; prv_outr = 1'b0;
        n_taken = 0; n_sent = 0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
            {in_ready, out_valid}, 2'b10);
        prv_inr = 1'b1; prv_outr = 1'b0;

        // Directed: full-rate stream, sink ready
        for (int i = 0; i < 30; i++) step(1'b1, 8'(i * 7), 1'b1);
        // Directed: saturation corner values (R7)
        step(1'b1, 8'hFF, 1'b1); step(1'b1, 8'hF0, 1'b1); step(1'b1, 8'hE5, 1'b1);
        step(1'b1, 8'hD0, 1'b1); step(1'b1, 8'hEF, 1'b1); step(1'b1, 8'h00, 1'b1);
        // Directed: sustained sink stall with source always valid (R9)
        for (int i = 0; i < 12; i++) step(1'b1, 8'(8'h40 + i), 1'b0);
        chk(in_ready == 1'b0, "R9 in_ready low in stall", in_ready, 0);
        chk(out_valid == 1'b0, "R9 no output in stall", out_valid, 0);
        chk(q_val.size() <= DEPTH, "R9 held within depth", q_val.size(), DEPTH);
        for (int i = 0; i < 8; i++) step(1'b0, 8'hAA, 1'b1);
        chk(q_val.size() == 0, "R9 stall backlog delivered", q_val.size(), 0);
        // Directed: single-cycle ready pulses
        for (int i = 0; i < 20; i++) step(1'b1, 8'(8'h80 + i), i[0]);
        // Random mix (R2 ignored samples arise whenever in_ready was low)
        for (int i = 0; i < 2500; i++)
            step(($urandom % 4) != 0, 8'($urandom), ($urandom % 3) != 0);
        // Drain
        for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 1'b1);
        chk(n_sent == n_taken, "R2 all taken samples delivered", n_sent, n_taken);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R2 idle after drain",
            {out_valid, in_ready}, 2'b01);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule